// File: doc/BRIEF.md
# Polled Device Controller Register Port

This block is a small register port that sits in the host's memory map and stands between a polling host and a byte-wide device. The host sees four 32-bit registers inside a 16-byte window: a status word, a control word, an input byte captured from the device and an output byte bound for the device. A host sends one byte by polling until the busy flag is clear, loading the output byte, and then writing the control word with the write command and the go bit set.

The port answers with an ordered handshake. It raises busy, offers the byte to the device on a valid/ready pair, and on acceptance drops the go flag and the error flag before it releases busy. If the device does not accept within a programmable number of cycles, the port ends the command with the error flag set. Bytes that the device sends back land in the input register and raise a service-request flag. A host read of the input register clears that flag, and a second byte that arrives before the read raises the error flag.

Top module: `polled_dev_port`

## Requirements
- R1: After reset every register reads 0 and tx_valid_o is low.
- R2: An access hits the port when bus_addr_i[ADDR_W-1:4] equals BASE_ADDR[ADDR_W-1:4]. bus_addr_i[3:2] selects 0 status, 1 control, 2 input byte and 3 output byte. Status bits are 0 busy, 1 go, 2 error and 3 service request. Control bits are 0 write command, 1 go and 31:16 timeout limit. Reads outside the window return 0, and writes outside it change nothing.
- R3: A control write that sets go while the port is idle shows go in status on the next cycle, and busy is set one cycle after that.
- R4: For a write command, tx_valid_o goes high in the cycle that busy rises and carries the output byte on tx_data_o, which does not change while valid is high.
- R5: When the device accepts the byte, go and error read 0 while busy still reads 1, and busy clears one cycle later.
- R6: With timeout limit L, tx_valid_o stays high for at most L+1 cycles. If the device does not accept the byte, the port ends the command with error set and go cleared, and busy clears one cycle after that.
- R7: A go without the write command bit sets busy and error, clears go, never raises tx_valid_o, and clears busy one cycle later.
- R8: A device byte on rx_valid_i is stored in the input byte register and sets the service-request bit.
- R9: A host read of the input byte clears the service-request bit. A device byte that arrives while that bit is still set replaces the stored byte and sets error.
- R10: Host writes to control or to the output byte are ignored while busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Host access strobe |
| bus_we_i | input | 1 | Host write (1) or read (0) |
| bus_addr_i | input | ADDR_W | Host byte address |
| bus_wdata_i | input | DATA_W | Host write data |
| bus_rdata_o | output | DATA_W | Host read data, combinational |
| tx_valid_o | output | 1 | Byte offered to device |
| tx_data_o | output | BYTE_W | Byte to device |
| tx_ready_i | input | 1 | Device accepts byte |
| rx_valid_i | input | 1 | Device byte strobe |
| rx_data_i | input | BYTE_W | Byte from device |

## Verification
Send commands are tried with random bytes, random timeout limits from 0 to 5 and random device accept delays from 0 to 7. This separates acceptance on the last allowed cycle from a timeout one cycle later. Directed cases cover a go without the write bit, writes made while busy, and accesses just outside the address window. Receive traffic is tried both with a read after each byte, which must leave error clear, and with back-to-back bytes, which must set error and keep the newer byte. A successful send after an overrun shows that success clears the error flag.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int NREG  = 4;
  localparam int IDX_W = 2;

  localparam logic [IDX_W-1:0] IDX_STAT = 2'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL = 2'd1;
  localparam logic [IDX_W-1:0] IDX_DIN  = 2'd2;
  localparam logic [IDX_W-1:0] IDX_DOUT = 2'd3;

  localparam int ST_BUSY = 0;
  localparam int ST_GO   = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_SRQ  = 3;

  localparam int CT_WR = 0;
  localparam int CT_GO = 1;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_XFER = 2'd1,
    HS_REL  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/pdp_decode.sv
module pdp_decode
  import pdp_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   wr_en_o,
  output logic [NREG-1:0]   rd_en_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int WIN_LSB = IDX_W + 2;

  logic hit;
  logic unused_lsb;

  assign unused_lsb = ^addr_i[1:0];
  assign hit   = sel_i && (addr_i[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign idx_o = addr_i[WIN_LSB-1:2];

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_en_o[i] = hit &&  we_i && (idx_o == IDX_W'(i));
    assign rd_en_o[i] = hit && !we_i && (idx_o == IDX_W'(i));
  end

  always_comb begin
    assert ($onehot0(wr_en_o | rd_en_o)) else $error("assert_onehot_sel_R2");
  end
endmodule

// File: rtl/pdp_rx.sv
module pdp_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rd_clr_i,
  output logic [BYTE_W-1:0] din_o,
  output logic              srq_o,
  output logic              ovr_o
);
  logic [BYTE_W-1:0] din_q;
  logic              srq_q;

  // overrun only when the held byte was not consumed on this same edge
  assign ovr_o = rx_valid_i && srq_q && !rd_clr_i;
  assign din_o = din_q;
  assign srq_o = srq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q <= '0;
      srq_q <= 1'b0;
    end else if (rx_valid_i) begin
      din_q <= rx_data_i;
      srq_q <= 1'b1;
    end else if (rd_clr_i) begin
      srq_q <= 1'b0;
    end
  end

  assert_srq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (srq_q && din_q == $past(rx_data_i)));

  assert_srq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !rx_valid_i) |=> !srq_q);
endmodule

// File: rtl/pdp_hshake.sv
module pdp_hshake
  import pdp_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             ctl_go_i,
  input  logic             wr_cmd_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic             ovr_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic             busy_o,
  output logic             go_o,
  output logic             err_o
);
  hs_state_e        state_q;
  logic [TMO_W-1:0] cnt_q;
  logic             busy_q, go_q, err_q;

  assign tx_valid_o = (state_q == HS_XFER);
  assign busy_o     = busy_q;
  assign go_o       = go_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (go_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            if (wr_cmd_i) begin
              state_q <= HS_XFER;
            end else begin
              go_q    <= 1'b0;
              err_q   <= 1'b1;
              state_q <= HS_REL;
            end
          end else if (ctl_we_i) begin
            go_q <= ctl_go_i;
          end
        end
        HS_XFER: begin
          if (tx_ready_i) begin
            go_q    <= 1'b0;
            err_q   <= 1'b0;
            state_q <= HS_REL;
          end else if (cnt_q == tmo_lim_i) begin
            go_q    <= 1'b0;
            err_q   <= 1'b1;
            state_q <= HS_REL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HS_REL: begin
          busy_q  <= 1'b0;
          state_q <= HS_IDLE;
        end
        default: state_q <= HS_IDLE;
      endcase
      // receive overrun wins over a success clear on the same edge
      if (ovr_i) err_q <= 1'b1;
    end
  end

  assert_busy_follows_go_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_IDLE && go_q) |=> busy_q);

  assert_valid_in_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (busy_q && go_q));

  assert_release_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (!go_q && $past(!go_q)));

  assert_timeout_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && cnt_q == tmo_lim_i) |=> (!tx_valid_o && err_q && !go_q));

  assert_nowrite_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_IDLE && go_q && !wr_cmd_i) |=> (err_q && !tx_valid_o));
endmodule

// File: rtl/polled_dev_port.sv
module polled_dev_port
  import pdp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 32,
  parameter int                BYTE_W    = 8,
  parameter int                TMO_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i
);
  localparam int TMO_LSB = DATA_W - TMO_W;
  localparam int CT_PAD  = TMO_LSB - 2;

  logic [NREG-1:0]   wr_en, rd_en;
  logic [IDX_W-1:0]  idx;
  logic              busy, go, err, srq, ovr;
  logic [BYTE_W-1:0] din;
  logic [BYTE_W-1:0] dout_q;
  logic              wr_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i[TMO_LSB-1:2];

  pdp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .sel_i   (bus_sel_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en),
    .idx_o   (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      wr_q   <= 1'b0;
      tmo_q  <= '0;
    end else if (!busy) begin
      if (wr_en[IDX_DOUT]) dout_q <= bus_wdata_i[BYTE_W-1:0];
      if (wr_en[IDX_CTRL]) begin
        wr_q  <= bus_wdata_i[CT_WR];
        tmo_q <= bus_wdata_i[DATA_W-1:TMO_LSB];
      end
    end
  end

  pdp_hshake #(.TMO_W(TMO_W)) u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (wr_en[IDX_CTRL] && !busy),
    .ctl_go_i   (bus_wdata_i[CT_GO]),
    .wr_cmd_i   (wr_q),
    .tmo_lim_i  (tmo_q),
    .ovr_i      (ovr),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .busy_o     (busy),
    .go_o       (go),
    .err_o      (err)
  );

  pdp_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rd_clr_i   (rd_en[IDX_DIN]),
    .din_o      (din),
    .srq_o      (srq),
    .ovr_o      (ovr)
  );

  assign tx_data_o = dout_q;

  always_comb begin
    bus_rdata_o = '0;
    if (|rd_en) begin
      unique case (idx)
        IDX_STAT: begin
          bus_rdata_o[ST_BUSY] = busy;
          bus_rdata_o[ST_GO]   = go;
          bus_rdata_o[ST_ERR]  = err;
          bus_rdata_o[ST_SRQ]  = srq;
        end
        IDX_CTRL: bus_rdata_o = {tmo_q, {CT_PAD{1'b0}}, go, wr_q};
        IDX_DIN:  bus_rdata_o[BYTE_W-1:0] = din;
        IDX_DOUT: bus_rdata_o[BYTE_W-1:0] = dout_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assert_dout_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(dout_q) && $stable(tmo_q) && $stable(wr_q)));

  assert_tx_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> $stable(tx_data_o));
endmodule

// File: tb/sim_polled_dev_port.sv
module sim_polled_dev_port;
  localparam logic [15:0] BASE = 16'h0040;
  localparam logic [15:0] A_ST = BASE + 16'h0;
  localparam logic [15:0] A_CT = BASE + 16'h4;
  localparam logic [15:0] A_DI = BASE + 16'h8;
  localparam logic [15:0] A_DO = BASE + 16'hC;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  int          total = 0, bad = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  polled_dev_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data)
  );

  function automatic logic [31:0] ctl_word(input int lim, input bit go, input bit wr);
    return {lim[15:0], 14'b0, go, wr};
  endfunction

  function automatic logic [2:0] st_low(input bit e, input bit g, input bit b);
    return {e, g, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // one send command; accept after d valid cycles, limit lim
  task automatic do_tx(input logic [7:0] b, input int lim, input int d);
    bit          exp_err;
    logic [31:0] st;
    exp_err = (d > lim);
    bus_write(A_CT, ctl_word(lim, 1'b0, 1'b1));
    bus_write(A_DO, {24'h0, b});
    bus_write(A_CT, ctl_word(lim, 1'b1, 1'b1));
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_ST;
    #1 st = bus_rdata;
    chk(st[1:0] == 2'b10, "R3 go before busy", st, 32'h2);
    for (int k = 0; k <= lim; k++) begin
      @(negedge clk); #1 st = bus_rdata;
      if (k == 0) chk(st[0] == 1'b1, "R3 busy", st, 32'h1);
      chk(tx_valid == 1'b1, "R4 valid", {31'h0, tx_valid}, 32'h1);
      chk(tx_data == b, "R4 data", {24'h0, tx_data}, {24'h0, b});
      if (k == d) begin
        tx_ready = 1'b1;
        break;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    #1 st = bus_rdata;
    chk(tx_valid == 1'b0, "R6 valid end", {31'h0, tx_valid}, 32'h0);
    chk(st[2:0] == st_low(exp_err, 1'b0, 1'b1), exp_err ? "R6 end step" : "R5 end step",
        st, {29'h0, st_low(exp_err, 1'b0, 1'b1)});
    @(negedge clk); #1 st = bus_rdata;
    chk(st[2:0] == st_low(exp_err, 1'b0, 1'b0), exp_err ? "R6 release" : "R5 release",
        st, {29'h0, st_low(exp_err, 1'b0, 1'b0)});
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] st;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk(tx_valid == 1'b0, "R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    bus_read(A_ST, rd); chk(rd == 32'h0, "R1 status", rd, 32'h0);
    bus_read(A_CT, rd); chk(rd == 32'h0, "R1 control", rd, 32'h0);
    bus_read(A_DI, rd); chk(rd == 32'h0, "R1 din", rd, 32'h0);
    bus_read(A_DO, rd); chk(rd == 32'h0, "R1 dout", rd, 32'h0);

    // R2 window and map
    bus_write(A_DO + 16'h0100, 32'h77);
    bus_write(A_DO - 16'h0010, 32'h66);
    bus_read(A_DO, rd); chk(rd == 32'h0, "R2 outside write", rd, 32'h0);
    bus_write(A_DO, 32'hA5);
    bus_read(A_DO, rd); chk(rd == 32'hA5, "R2 dout map", rd, 32'hA5);
    bus_read(A_DO + 16'h0100, rd); chk(rd == 32'h0, "R2 outside read", rd, 32'h0);
    bus_write(A_CT, ctl_word(9, 1'b0, 1'b1));
    bus_read(A_CT, rd); chk(rd == 32'h0009_0001, "R2 ctrl map", rd, 32'h0009_0001);

    // directed sends: immediate, last allowed cycle, one past limit
    do_tx(8'h3C, 3, 0);
    do_tx(8'hC3, 2, 2);
    do_tx(8'h81, 2, 3);
    do_tx(8'h18, 0, 0);

    // R7 go without write command
    bus_write(A_CT, ctl_word(4, 1'b1, 1'b0));
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_ST;
    #1 st = bus_rdata;
    chk(st[2:0] == 3'b010, "R7 go seen", st, 32'h2);
    @(negedge clk); #1 st = bus_rdata;
    chk(st[2:0] == 3'b101, "R7 err busy", st, 32'h5);
    chk(tx_valid == 1'b0, "R7 no valid", {31'h0, tx_valid}, 32'h0);
    @(negedge clk); #1 st = bus_rdata;
    chk(st[2:0] == 3'b100, "R7 release", st, 32'h4);
    chk(tx_valid == 1'b0, "R7 no valid late", {31'h0, tx_valid}, 32'h0);
    bus_sel = 1'b0;

    // R10 writes ignored while busy
    bus_write(A_CT, ctl_word(40, 1'b0, 1'b1));
    bus_write(A_DO, 32'h4E);
    bus_write(A_CT, ctl_word(40, 1'b1, 1'b1));
    repeat (2) @(negedge clk);
    bus_write(A_DO, 32'hB7);
    bus_write(A_CT, ctl_word(2, 1'b0, 1'b0));
    #1 chk(tx_valid && tx_data == 8'h4E, "R10 data held", {24'h0, tx_data}, 32'h4E);
    bus_read(A_CT, rd); chk(rd == 32'h0028_0003, "R10 ctrl held", rd, 32'h0028_0003);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(A_DO, rd); chk(rd == 32'h4E, "R10 dout held", rd, 32'h4E);
    bus_read(A_ST, rd); chk(rd[2:0] == 3'b000, "R5 success status", rd, 32'h0);

    // R8 / R9 receive path
    rx_put(8'h5D);
    bus_read(A_ST, rd); chk(rd[3:0] == 4'b1000, "R8 srq set", rd, 32'h8);
    bus_read(A_DI, rd); chk(rd == 32'h5D, "R8 din", rd, 32'h5D);
    bus_read(A_ST, rd); chk(rd[3] == 1'b0, "R9 srq cleared", rd, 32'h0);
    rx_put(8'h11);
    rx_put(8'h22);
    bus_read(A_ST, rd); chk(rd[3:2] == 2'b11, "R9 overrun err", rd, 32'hC);
    bus_read(A_DI, rd); chk(rd == 32'h22, "R9 newer byte", rd, 32'h22);
    bus_read(A_ST, rd); chk(rd[3] == 1'b0, "R9 srq cleared 2", rd, 32'h4);
    do_tx(8'h99, 5, 1);

    // random sends
    for (int i = 0; i < 40; i++) begin
      do_tx(8'($urandom), int'($urandom % 6), int'($urandom % 8));
    end

    // random receive with read in between: no error
    for (int i = 0; i < 20; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      rx_put(b);
      bus_read(A_DI, rd); chk(rd == {24'h0, b}, "R8 random din", rd, {24'h0, b});
      bus_read(A_ST, rd); chk(rd[3] == 1'b0, "R9 random clear", rd, 32'h0);
    end
    do_tx(8'h42, 3, 1);
    bus_read(A_ST, rd); chk(rd[3:0] == 4'h0, "R5 final status", rd, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule